// File: doc/BRIEF.md
# I/O Activity Event Decoder

This block watches the traffic of a legacy system bus and reports user-visible activity to the power manager. Each clock it looks at one bus cycle: an I/O or memory strobe with its address, the interrupt request lines and a DMA/bus-master activity flag. It sorts that activity into an 8-bit vector of primary events covering keyboard, serial, parallel, video and disk accesses, primary interrupts and DMA. A per-event enable mask gates the vector. Each enabled event sets a sticky status bit, and any enabled event in a cycle produces a single-clock reload pulse for the inactivity timer.

Every interrupt channel has one of three classes: primary, secondary or ignored. A rising request on a primary channel is a primary event. A rising request on a secondary channel only raises a secondary-event pulse, so background housekeeping never keeps the system awake. When the wake enable is set, any pending status raises a management interrupt, which lets a primary event bring the system back from power-down.

There is no back-pressure anywhere. The block observes a cycle in every clock where `cyc_vld` is high and never stalls the bus. All results are registered and appear just after the clock edge that samples the inputs.

Top module: `act_evt_decoder`

## Requirements
- R1: An I/O cycle (`cyc_vld`=1, `cyc_is_mem`=0) at address 0060h sets status bit 7 (keyboard).
- R2: An I/O cycle in 2E8h–2EFh, 2F8h–2FFh, 3E8h–3EFh or 3F8h–3FFh sets status bit 6 (serial).
- R3: An I/O cycle in 278h–27Fh or 378h–37Fh sets status bit 5 (parallel).
- R4: An I/O cycle in 3B0h–3DFh sets status bit 4 (video). A memory cycle (`cyc_is_mem`=1) at A0000h–BFFFFh also sets bit 4, and no memory cycle sets any other bit.
- R5: An I/O cycle in 170h–177h or 1F0h–1F7h, or at 3F5h, sets status bit 3 (disk). Status bit 2 always reads 0.
- R6: Channel i takes its class from `irq_class[2i+1:2i]`: 01 is primary, 10 is secondary, and 00 or 11 is ignored. A 0-to-1 change of a primary line sets bit 1. A 0-to-1 change of a secondary line pulses `sec_pulse` for one clock and sets no status. An ignored line does nothing. A line held high does not fire again.
- R7: `dma_active` high in a cycle sets status bit 0.
- R8: An event whose bit in `evt_en` is 0 sets no status and causes no reload.
- R9: `reload_pulse` is high for exactly the one clock after each cycle that holds at least one enabled event, and is low otherwise.
- R10: Status bits stay set until a clock where the matching `sts_clr` bit is 1. If a new event arrives in the same clock as its clear, the bit stays set.
- R11: `wake_irq` is high exactly when `wake_en` is 1 and at least one status bit is set.
- R12: Address decoding uses only cycles with `cyc_vld`=1. The I/O windows use `cyc_addr[15:0]` and apply only when `cyc_is_mem`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_vld | input | 1 | A bus cycle is present this clock |
| cyc_is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| cyc_addr | input | 20 | Cycle address (I/O uses bits 15:0) |
| irq_req | input | 16 | Interrupt request lines |
| irq_class | input | 32 | Two class bits per channel |
| dma_active | input | 1 | DMA or bus-master activity |
| evt_en | input | 8 | Per-event enable mask |
| sts_clr | input | 8 | Write-1-to-clear strobe for status |
| wake_en | input | 1 | Enables the management interrupt |
| evt_sts | output | 8 | Sticky event status |
| reload_pulse | output | 1 | Inactivity-timer reload |
| sec_pulse | output | 1 | Secondary interrupt seen |
| wake_irq | output | 1 | Management wake interrupt |

## Verification
The bench goes through all 65536 I/O addresses with every event enabled and clears status in every cycle. A window with an off-by-one edge would show up at exactly one address, for example 3F5h confused with the serial block or 3DFh lost from video. It also steps through the memory space at each 4 KB page edge, which catches a segment decode that strays into C0000h or that lets memory cycles set the I/O bits. It tries every enable mask against simultaneous keyboard and DMA activity, so a design that records disabled events or pulses the reload for them would fail. It also tries every interrupt channel in every class, including a held-high line, which exposes a level-sensitive detector, a secondary interrupt that reloads the timer, and a clear that beats a same-cycle set.

// File: rtl/act_evt_pkg.sv
package act_evt_pkg;
  typedef enum logic [1:0] {
    IRQC_OFF   = 2'b00,
    IRQC_PRI   = 2'b01,
    IRQC_SEC   = 2'b10,
    IRQC_OFF2  = 2'b11
  } irq_class_e;

  localparam int EVT_W     = 8;
  localparam int EB_KBD    = 7;
  localparam int EB_SER    = 6;
  localparam int EB_PAR    = 5;
  localparam int EB_VID    = 4;
  localparam int EB_DSK    = 3;
  localparam int EB_RSV    = 2;
  localparam int EB_PIRQ   = 1;
  localparam int EB_DMA    = 0;
  localparam logic [EVT_W-1:0] RSV_MASK = 8'b0000_0100;
endpackage

// File: rtl/act_addr_classify.sv
module act_addr_classify #(
  parameter int IO_AW  = 16,
  parameter int MEM_AW = 20
) (
  input  logic              cyc_vld,
  input  logic              cyc_is_mem,
  input  logic [MEM_AW-1:0] cyc_addr,
  output logic              hit_kbd,
  output logic              hit_ser,
  output logic              hit_par,
  output logic              hit_vid,
  output logic              hit_dsk
);
  // I/O ports decoded in 8-port blocks: compare address bits above bit 2
  localparam int BLK = 3;
  localparam int BW  = IO_AW - BLK;
  localparam int SEGW = 3;

  logic [IO_AW-1:0] io_a;
  logic [BW-1:0]    io_blk;
  logic             io_cyc, mem_cyc;

  assign io_a    = cyc_addr[IO_AW-1:0];
  assign io_blk  = io_a[IO_AW-1:BLK];
  assign io_cyc  = cyc_vld & ~cyc_is_mem;
  assign mem_cyc = cyc_vld &  cyc_is_mem;

  function automatic logic blk_is(input logic [BW-1:0] b, input int base);
    return b == BW'(base >> BLK);
  endfunction

  always_comb begin
    hit_kbd = io_cyc && (io_a == IO_AW'(16'h0060));
    hit_ser = io_cyc && (blk_is(io_blk, 'h3F8) || blk_is(io_blk, 'h2F8) ||
                         blk_is(io_blk, 'h3E8) || blk_is(io_blk, 'h2E8));
    hit_par = io_cyc && (blk_is(io_blk, 'h378) || blk_is(io_blk, 'h278));
    hit_dsk = io_cyc && (blk_is(io_blk, 'h1F0) || blk_is(io_blk, 'h170) ||
                         (io_a == IO_AW'(16'h03F5)));
    // video: 3B0h..3DFh is six 8-port blocks starting at 3B0h
    hit_vid = (io_cyc && (io_blk >= BW'('h3B0 >> BLK)) &&
                         (io_blk <= BW'('h3D8 >> BLK))) ||
              (mem_cyc && (cyc_addr[MEM_AW-1 -: SEGW] == 3'b101));
  end
endmodule

// File: rtl/act_irq_classify.sv
module act_irq_classify
  import act_evt_pkg::*;
#(
  parameter int NIRQ = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIRQ-1:0]   irq_req,
  input  logic [2*NIRQ-1:0] irq_class,
  output logic              pri_rise,
  output logic              sec_rise
);
  logic [NIRQ-1:0] irq_q, rise, is_pri, is_sec;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_req;
  end

  assign rise = irq_req & ~irq_q;

  for (genvar i = 0; i < NIRQ; i++) begin : g_ch
    irq_class_e cls;
    assign cls       = irq_class_e'(irq_class[2*i +: 2]);
    assign is_pri[i] = (cls == IRQC_PRI);
    assign is_sec[i] = (cls == IRQC_SEC);
  end

  assign pri_rise = |(rise & is_pri);
  assign sec_rise = |(rise & is_sec);
endmodule

// File: rtl/act_status_reg.sv
module act_status_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] ZERO_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] sts
);
  logic [W-1:0] sts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= ((sts_q & ~clr_vec) | set_vec) & ~ZERO_MASK;
  end

  assign sts = sts_q;
endmodule

// File: rtl/act_evt_decoder.sv
module act_evt_decoder
  import act_evt_pkg::*;
#(
  parameter int NIRQ   = 16,
  parameter int IO_AW  = 16,
  parameter int MEM_AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_vld,
  input  logic              cyc_is_mem,
  input  logic [MEM_AW-1:0] cyc_addr,
  input  logic [NIRQ-1:0]   irq_req,
  input  logic [2*NIRQ-1:0] irq_class,
  input  logic              dma_active,
  input  logic [EVT_W-1:0]  evt_en,
  input  logic [EVT_W-1:0]  sts_clr,
  input  logic              wake_en,
  output logic [EVT_W-1:0]  evt_sts,
  output logic              reload_pulse,
  output logic              sec_pulse,
  output logic              wake_irq
);
  logic hit_kbd, hit_ser, hit_par, hit_vid, hit_dsk;
  logic pri_rise, sec_rise;
  logic [EVT_W-1:0] raw_evt, qual_evt;
  logic reload_q, sec_q;

  act_addr_classify #(.IO_AW(IO_AW), .MEM_AW(MEM_AW)) u_addr (
    .cyc_vld    (cyc_vld),
    .cyc_is_mem (cyc_is_mem),
    .cyc_addr   (cyc_addr),
    .hit_kbd    (hit_kbd),
    .hit_ser    (hit_ser),
    .hit_par    (hit_par),
    .hit_vid    (hit_vid),
    .hit_dsk    (hit_dsk)
  );

  act_irq_classify #(.NIRQ(NIRQ)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .irq_class (irq_class),
    .pri_rise  (pri_rise),
    .sec_rise  (sec_rise)
  );

  always_comb begin
    raw_evt          = '0;
    raw_evt[EB_KBD]  = hit_kbd;
    raw_evt[EB_SER]  = hit_ser;
    raw_evt[EB_PAR]  = hit_par;
    raw_evt[EB_VID]  = hit_vid;
    raw_evt[EB_DSK]  = hit_dsk;
    raw_evt[EB_PIRQ] = pri_rise;
    raw_evt[EB_DMA]  = dma_active;
  end

  assign qual_evt = raw_evt & evt_en & ~RSV_MASK;

  act_status_reg #(.W(EVT_W), .ZERO_MASK(RSV_MASK)) u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (qual_evt),
    .clr_vec (sts_clr),
    .sts     (evt_sts)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= 1'b0;
      sec_q    <= 1'b0;
    end else begin
      reload_q <= |qual_evt;
      sec_q    <= sec_rise;
    end
  end

  assign reload_pulse = reload_q;
  assign sec_pulse    = sec_q;
  assign wake_irq     = wake_en & (|evt_sts);
endmodule

// File: rtl/act_evt_checker.sv
module act_evt_checker #(
  parameter int EW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [EW-1:0] evt_en,
  input logic [EW-1:0] sts_clr,
  input logic          wake_en,
  input logic [EW-1:0] evt_sts,
  input logic          reload_pulse,
  input logic          wake_irq
);
  // R5
  rsv_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_sts[2]);

  // R9
  reload_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |-> (evt_sts != '0));

  // R8
  only_enabled_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_sts & ~$past(evt_sts) & ~$past(evt_en)) == '0));

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_sts) & ~$past(sts_clr) & ~evt_sts) == '0));

  // R11
  wake_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> wake_en);

  // R11
  wake_on_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en && reload_pulse) |-> wake_irq);
endmodule

bind act_evt_decoder act_evt_checker #(.EW(8)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_en       (evt_en),
  .sts_clr      (sts_clr),
  .wake_en      (wake_en),
  .evt_sts      (evt_sts),
  .reload_pulse (reload_pulse),
  .wake_irq     (wake_irq)
);

// File: tb/sim_act_evt_decoder.sv
`timescale 1ns/1ps
module sim_act_evt_decoder;
  localparam int NIRQ = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_vld = 1'b0, cyc_is_mem = 1'b0;
  logic [19:0] cyc_addr = '0;
  logic [NIRQ-1:0]   irq_req = '0;
  logic [2*NIRQ-1:0] irq_class = '0;
  logic        dma_active = 1'b0;
  logic [7:0]  evt_en = '0, sts_clr = '0;
  logic        wake_en = 1'b0;
  logic [7:0]  evt_sts;
  logic        reload_pulse, sec_pulse, wake_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  act_evt_decoder #(.NIRQ(NIRQ)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .cyc_is_mem(cyc_is_mem),
    .cyc_addr(cyc_addr), .irq_req(irq_req), .irq_class(irq_class),
    .dma_active(dma_active), .evt_en(evt_en), .sts_clr(sts_clr),
    .wake_en(wake_en), .evt_sts(evt_sts), .reload_pulse(reload_pulse),
    .sec_pulse(sec_pulse), .wake_irq(wake_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_io(input int a);
    logic [7:0] e = '0;
    e[7] = (a == 'h60);
    e[6] = (a >= 'h3F8 && a <= 'h3FF) || (a >= 'h2F8 && a <= 'h2FF) ||
           (a >= 'h3E8 && a <= 'h3EF) || (a >= 'h2E8 && a <= 'h2EF);
    e[5] = (a >= 'h378 && a <= 'h37F) || (a >= 'h278 && a <= 'h27F);
    e[4] = (a >= 'h3B0 && a <= 'h3DF);
    e[3] = (a >= 'h1F0 && a <= 'h1F7) || (a >= 'h170 && a <= 'h177) || (a == 'h3F5);
    return e;
  endfunction

  // apply inputs at negedge, then sample one ns after the next posedge
  task automatic step;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(evt_sts == 0 && !reload_pulse && !sec_pulse && !wake_irq, "reset R9", evt_sts, 0);

    // R1 R2 R3 R4 R5 R12: every I/O address, every event enabled, clear each cycle
    evt_en = 8'hFF; sts_clr = 8'hFF;
    for (int a = 0; a < 65536; a++) begin
      @(negedge clk);
      cyc_vld = 1; cyc_is_mem = 0; cyc_addr = 20'(a) | 20'hF0000;
      step();
      e = exp_io(a);
      chk(evt_sts == e, "R1 R2 R3 R4 R5 R12 io decode", evt_sts, e);
      chk(reload_pulse == (e != 0), "R9 io reload", reload_pulse, e != 0);
    end

    // R4: memory page edges
    for (int p = 0; p < 256; p++) begin
      for (int lo = 0; lo < 2; lo++) begin
        int ma = p * 4096 + (lo ? 4095 : 0);
        @(negedge clk);
        cyc_is_mem = 1; cyc_addr = 20'(ma);
        step();
        e = (ma >= 'hA0000 && ma <= 'hBFFFF) ? 8'h10 : 8'h00;
        chk(evt_sts == e, "R4 memory segment", evt_sts, e);
      end
    end

    // R12: no strobe, keyboard address present
    @(negedge clk);
    cyc_vld = 0; cyc_is_mem = 0; cyc_addr = 20'h00060;
    step();
    chk(evt_sts == 0 && !reload_pulse, "R12 no strobe", evt_sts, 0);

    // R7 R8 R9: all enable masks against keyboard + DMA together
    for (int m = 0; m < 256; m++) begin
      @(negedge clk);
      cyc_vld = 1; cyc_addr = 20'h00060; dma_active = 1; evt_en = 8'(m);
      step();
      e = 8'(m) & 8'h81;
      chk(evt_sts == e, "R7 R8 enable mask", evt_sts, e);
      chk(reload_pulse == (e != 0), "R9 R8 reload gating", reload_pulse, e != 0);
    end
    @(negedge clk);
    cyc_vld = 0; dma_active = 0; evt_en = 8'hFF;
    step();
    chk(!reload_pulse, "R9 reload one clock", reload_pulse, 0);

    // R6: every channel in every class
    for (int ch = 0; ch < NIRQ; ch++) begin
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        irq_class = '0; irq_class[2*ch +: 2] = 2'(c); irq_req = '0;
        step();
        @(negedge clk);
        irq_req[ch] = 1'b1;
        step();
        chk(evt_sts[1] == (c == 1) && reload_pulse == (c == 1), "R6 primary irq",
            {evt_sts[1], reload_pulse}, (c == 1) ? 3 : 0);
        chk(sec_pulse == (c == 2), "R6 secondary irq", sec_pulse, c == 2);
        @(negedge clk);  // held high: no new event
        step();
        chk(evt_sts == 0 && !sec_pulse && !reload_pulse, "R6 held line", evt_sts, 0);
      end
    end
    @(negedge clk);
    irq_req = '0;
    step();

    // R10 R11: sticky, clear, set beats clear, wake
    @(negedge clk);
    sts_clr = 0; wake_en = 1; cyc_vld = 1; cyc_addr = 20'h00378;
    step();
    chk(evt_sts == 8'h20 && wake_irq, "R10 R11 set and wake", evt_sts, 8'h20);
    @(negedge clk);
    cyc_vld = 0;
    repeat (3) step();
    chk(evt_sts == 8'h20, "R10 sticky hold", evt_sts, 8'h20);
    @(negedge clk);
    wake_en = 0;
    #1 chk(!wake_irq, "R11 wake disabled", wake_irq, 0);
    @(negedge clk);
    wake_en = 1; cyc_vld = 1; sts_clr = 8'h20;
    step();
    chk(evt_sts == 8'h20, "R10 set beats clear", evt_sts, 8'h20);
    @(negedge clk);
    cyc_vld = 0; sts_clr = 8'h20;
    step();
    chk(evt_sts == 0 && !wake_irq, "R10 R11 cleared", evt_sts, 0);
    @(negedge clk);
    sts_clr = 8'hFF; evt_en = 8'hFF; dma_active = 0;
    step();
    chk(evt_sts[2] == 0, "R5 reserved bit", evt_sts, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule